// File: doc/BRIEF.md
# Multi-Queue Descriptor Pointer Manager

This block keeps a set of independent first-in first-out queues of 32-bit descriptor pointers in one shared storage array. Every queue has a fixed number of slots. Software works through a flat, word-addressed register window. Writing a pointer to a queue's slot address appends it. Reading that same address removes the oldest entry and returns it.

Two further windows show each queue's state without changing it. One carries bitmaps of the non-empty queues and of the queues that overflowed. The other gives a per-queue occupancy count. A single shared reset register empties whichever queue number is written to it.

The port has a write channel and a read channel that may both be active in the same cycle. Read data comes back, with a valid strobe, in the cycle after the read request. All addresses below are byte offsets. The word address presented on the ports is the byte offset divided by four.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset every queue is empty, every count reads 0 and both bitmaps read 0. Read data appears with `rvalid` high in exactly the cycle after `rd_en`, and `rvalid` is low in any cycle that follows one without `rd_en`.
- R2: Writing to byte offset 0x0D00 + 4*q appends the data to queue q (q = 0..63). Reading that offset returns the entries in the order they were written.
- R3: Reading 0x0D00 + 4*q while queue q is empty returns 0xFFFFFFFF and changes no state.
- R4: Reading 0x0E40 + 4*q returns the occupancy of queue q, zero-extended, with no side effect. A count read in the same cycle as a push to that queue returns the value from before the push.
- R5: In the status window at 0x0E00, word 0 bit i shows queue i non-empty and word 1 bit i shows queue 32+i non-empty. Words 2 and 3 use the same layout for the sticky overflow flags. Words 4 to 15 read 0.
- R6: Each queue holds 16 entries. A push to a full queue is dropped, leaves the stored entries unchanged and sets that queue's overflow flag. The flag stays set across later pops.
- R7: Writing to 0x0F40 empties the queue named by data bits [5:0] and clears its overflow flag. Upper data bits are ignored and other queues are untouched.
- R8: When a reset and a pop hit the same queue in the same cycle, the reset wins: the queue ends empty and the pop returns 0xFFFFFFFF.
- R9: A push and a pop to the same queue in one cycle both take effect, even when the queue is full. No overflow is flagged and the count is unchanged.
- R10: Writes to the status window, the count window or unmapped addresses change nothing. Reads of the reset register or of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 10 | Word address of the read |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 32 | Read data |

## Verification
The bench fills a queue past its depth, which also makes the head and tail indices wrap. A design with a bad full test would either lose the oldest entry or accept a seventeenth one, and both show up in the drained order. Same-cycle collisions are driven on purpose: reset against pop, and push against pop on a full queue. A wrong priority would return a stale pointer, leave entries behind after a reset, or raise a false overflow. Side-effect-free reads are checked by reading counts twice and by reading a count in the same cycle as a push. A design that popped or updated early would show a count that moves.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_QUEUE,
        REG_PEEK,
        REG_COUNT,
        REG_RESET
    } reg_sel_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_POP,
        RK_VALUE
    } rd_kind_e;

endpackage

// File: rtl/dqm_decode.sv
module dqm_decode
    import dqm_pkg::*;
#(
    parameter int AW         = 10,
    parameter int NUM_Q      = 64,
    parameter int QW         = 6,
    parameter int Q_BASE     = 'h340,
    parameter int PEEK_BASE  = 'h380,
    parameter int PEEK_WORDS = 16,
    parameter int CNT_BASE   = 'h390,
    parameter int RST_ADDR   = 'h3D0
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output logic [QW-1:0] idx
);
    localparam logic [AW-1:0] Q_LO = AW'(Q_BASE);
    localparam logic [AW-1:0] Q_HI = AW'(Q_BASE + NUM_Q);
    localparam logic [AW-1:0] P_LO = AW'(PEEK_BASE);
    localparam logic [AW-1:0] P_HI = AW'(PEEK_BASE + PEEK_WORDS);
    localparam logic [AW-1:0] C_LO = AW'(CNT_BASE);
    localparam logic [AW-1:0] C_HI = AW'(CNT_BASE + NUM_Q);
    localparam logic [AW-1:0] R_AD = AW'(RST_ADDR);

    always_comb begin
        sel = REG_NONE;
        idx = '0;
        if (addr >= Q_LO && addr < Q_HI) begin
            sel = REG_QUEUE;
            idx = QW'(addr - Q_LO);
        end else if (addr >= P_LO && addr < P_HI) begin
            sel = REG_PEEK;
            idx = QW'(addr - P_LO);
        end else if (addr >= C_LO && addr < C_HI) begin
            sel = REG_COUNT;
            idx = QW'(addr - C_LO);
        end else if (addr == R_AD) begin
            sel = REG_RESET;
        end
    end

endmodule

// File: rtl/dqm_ptr_file.sv
module dqm_ptr_file #(
    parameter int NUM_Q = 64,
    parameter int DEPTH = 16,
    parameter int QW    = 6,
    parameter int PW    = 4,
    parameter int CW    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_en,
    input  logic [QW-1:0]              push_q,
    input  logic                       pop_req,
    input  logic [QW-1:0]              pop_q,
    input  logic                       clr_en,
    input  logic [QW-1:0]              clr_q,
    output logic                       push_ok,
    output logic                       pop_ok,
    output logic [QW+PW-1:0]           wr_slot,
    output logic [QW+PW-1:0]           rd_slot,
    output logic [NUM_Q-1:0][CW-1:0]   cnt,
    output logic [NUM_Q-1:0]           nonempty,
    output logic [NUM_Q-1:0]           ovf
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [NUM_Q-1:0][PW-1:0] head;
        logic [NUM_Q-1:0][PW-1:0] tail;
        logic [NUM_Q-1:0][CW-1:0] cnt;
        logic [NUM_Q-1:0]         ovf;
    } state_t;

    state_t st_d, st_q;
    logic   pop_clash, push_clash, push_full, same_q;

    always_comb begin
        st_d       = st_q;
        same_q     = (push_q == pop_q);
        pop_clash  = clr_en && (clr_q == pop_q);
        push_clash = clr_en && (clr_q == push_q);
        pop_ok     = pop_req && (st_q.cnt[pop_q] != '0) && !pop_clash;
        push_full  = (st_q.cnt[push_q] == FULL) && !(pop_ok && same_q);
        push_ok    = push_en && !push_clash && !push_full;
        wr_slot    = {push_q, st_q.tail[push_q]};
        rd_slot    = {pop_q, st_q.head[pop_q]};

        for (int q = 0; q < NUM_Q; q++) begin
            logic inc, dec;
            inc = push_ok && (push_q == QW'(q));
            dec = pop_ok && (pop_q == QW'(q));
            if (clr_en && clr_q == QW'(q)) begin
                st_d.head[q] = '0;
                st_d.tail[q] = '0;
                st_d.cnt[q]  = '0;
                st_d.ovf[q]  = 1'b0;
            end else begin
                if (inc) st_d.tail[q] = st_q.tail[q] + PW'(1);
                if (dec) st_d.head[q] = st_q.head[q] + PW'(1);
                st_d.cnt[q] = st_q.cnt[q] + CW'(inc) - CW'(dec);
                if (push_en && push_q == QW'(q) && push_full)
                    st_d.ovf[q] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cnt = st_q.cnt;
        ovf = st_q.ovf;
        for (int q = 0; q < NUM_Q; q++)
            nonempty[q] = (st_q.cnt[q] != '0);
    end

endmodule

// File: rtl/dqm_store.sv
module dqm_store #(
    parameter int DW    = 32,
    parameter int SLOTS = 1024,
    parameter int SW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [SW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [SLOTS];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
    import dqm_pkg::*;
#(
    parameter int NUM_Q     = 64,
    parameter int DEPTH     = 16,
    parameter int DW        = 32,
    parameter int AW        = 10,
    parameter int Q_BASE    = 'h340,
    parameter int PEEK_BASE = 'h380,
    parameter int CNT_BASE  = 'h390,
    parameter int RST_ADDR  = 'h3D0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    localparam int QW         = $clog2(NUM_Q);
    localparam int PW         = $clog2(DEPTH);
    localparam int CW         = PW + 1;
    localparam int SW         = QW + PW;
    localparam int PEEK_WORDS = 16;
    localparam int BM_WORDS   = (NUM_Q + DW - 1) / DW;
    localparam int BMW        = BM_WORDS * DW;

    typedef struct packed {
        rd_kind_e      kind;
        logic [DW-1:0] val;
    } rd_t;

    reg_sel_e                 wr_sel, rd_sel;
    logic [QW-1:0]            wr_idx, rd_idx;
    logic                     push_en, pop_req, clr_en;
    logic                     push_ok, pop_ok;
    logic [SW-1:0]            wr_slot, rd_slot;
    logic [NUM_Q-1:0][CW-1:0] cnt_flat;
    logic [NUM_Q-1:0]         nonempty, ovf;
    logic [BMW-1:0]           ne_pad, ov_pad;
    logic [DW-1:0]            mem_rdata;
    rd_t                      rd_d, rd_q;

    dqm_decode #(
        .AW(AW), .NUM_Q(NUM_Q), .QW(QW), .Q_BASE(Q_BASE),
        .PEEK_BASE(PEEK_BASE), .PEEK_WORDS(PEEK_WORDS),
        .CNT_BASE(CNT_BASE), .RST_ADDR(RST_ADDR)
    ) wr_dec_i (
        .addr(wr_addr), .sel(wr_sel), .idx(wr_idx)
    );

    dqm_decode #(
        .AW(AW), .NUM_Q(NUM_Q), .QW(QW), .Q_BASE(Q_BASE),
        .PEEK_BASE(PEEK_BASE), .PEEK_WORDS(PEEK_WORDS),
        .CNT_BASE(CNT_BASE), .RST_ADDR(RST_ADDR)
    ) rd_dec_i (
        .addr(rd_addr), .sel(rd_sel), .idx(rd_idx)
    );

    assign push_en = wr_en && (wr_sel == REG_QUEUE);
    assign clr_en  = wr_en && (wr_sel == REG_RESET);
    assign pop_req = rd_en && (rd_sel == REG_QUEUE);

    dqm_ptr_file #(
        .NUM_Q(NUM_Q), .DEPTH(DEPTH), .QW(QW), .PW(PW), .CW(CW)
    ) ptr_i (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_q(wr_idx),
        .pop_req(pop_req), .pop_q(rd_idx),
        .clr_en(clr_en), .clr_q(wr_data[QW-1:0]),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .wr_slot(wr_slot), .rd_slot(rd_slot),
        .cnt(cnt_flat), .nonempty(nonempty), .ovf(ovf)
    );

    dqm_store #(
        .DW(DW), .SLOTS(NUM_Q * DEPTH), .SW(SW)
    ) store_i (
        .clk(clk),
        .we(push_ok), .waddr(wr_slot), .wdata(wr_data),
        .re(pop_ok), .raddr(rd_slot), .rdata(mem_rdata)
    );

    assign ne_pad = BMW'(nonempty);
    assign ov_pad = BMW'(ovf);

    always_comb begin
        rd_d = '{kind: RK_NONE, val: '0};
        if (rd_en) begin
            rd_d.kind = RK_VALUE;
            unique case (rd_sel)
                REG_QUEUE: begin
                    if (pop_ok) rd_d.kind = RK_POP;
                    else        rd_d.val  = '1;
                end
                REG_PEEK: begin
                    for (int k = 0; k < BM_WORDS; k++) begin
                        if (rd_idx == QW'(k))
                            rd_d.val = ne_pad[k*DW +: DW];
                        if (rd_idx == QW'(BM_WORDS + k))
                            rd_d.val = ov_pad[k*DW +: DW];
                    end
                end
                REG_COUNT: rd_d.val = DW'(cnt_flat[rd_idx]);
                default:   rd_d.val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '{kind: RK_NONE, val: '0};
        else        rd_q <= rd_d;
    end

    assign rvalid = (rd_q.kind != RK_NONE);
    assign rdata  = (rd_q.kind == RK_POP) ? mem_rdata : rd_q.val;

endmodule

// File: rtl/desc_queue_mgr_chk.sv
module desc_queue_mgr_chk #(
    parameter int NUM_Q    = 64,
    parameter int DEPTH    = 16,
    parameter int DW       = 32,
    parameter int AW       = 10,
    parameter int Q_BASE   = 'h340,
    parameter int RST_ADDR = 'h3D0
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   wr_en,
    input logic [AW-1:0]                          wr_addr,
    input logic [DW-1:0]                          wr_data,
    input logic                                   rd_en,
    input logic [AW-1:0]                          rd_addr,
    input logic                                   rvalid,
    input logic [DW-1:0]                          rdata,
    input logic [NUM_Q-1:0][$clog2(DEPTH):0]      cnt_flat
);
    localparam int QW = $clog2(NUM_Q);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [AW-1:0] Q_LO = AW'(Q_BASE);
    localparam logic [AW-1:0] Q_HI = AW'(Q_BASE + NUM_Q);
    localparam logic [AW-1:0] R_AD = AW'(RST_ADDR);

    logic          rd_is_q, over_any, rst_wr;
    logic [QW-1:0] rq, clr_q_r;

    assign rd_is_q = (rd_addr >= Q_LO) && (rd_addr < Q_HI);
    assign rq      = QW'(rd_addr - Q_LO);
    assign rst_wr  = wr_en && (wr_addr == R_AD);

    always_comb begin
        over_any = 1'b0;
        for (int q = 0; q < NUM_Q; q++)
            if (cnt_flat[q] > CW'(DEPTH)) over_any = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_wr) clr_q_r <= wr_data[QW-1:0];
    end

    // R1: a read returns data in the next cycle only
    a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    a_r1_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R3: a pop of an empty queue yields all ones
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_is_q && cnt_flat[rq] == '0) |=> (rdata == '1));

    // R6: no queue ever holds more than its depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !over_any);

    // R7: a reset write leaves the named queue empty
    a_r7_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (cnt_flat[clr_q_r] == '0));

endmodule

bind desc_queue_mgr desc_queue_mgr_chk #(
    .NUM_Q(NUM_Q), .DEPTH(DEPTH), .DW(DW), .AW(AW),
    .Q_BASE(Q_BASE), .RST_ADDR(RST_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rvalid(rvalid), .rdata(rdata),
    .cnt_flat(cnt_flat)
);

// File: tb/desc_queue_mgr_tb_top.sv
module desc_queue_mgr_tb_top;

    localparam logic [11:0] QB = 12'hD00;
    localparam logic [11:0] PB = 12'hE00;
    localparam logic [11:0] CB = 12'hE40;
    localparam logic [11:0] RB = 12'hF40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [9:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rvalid;
    logic [31:0] rdata;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    desc_queue_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rvalid(rvalid), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [11:0] wa, input logic [31:0] wd,
                          input logic re, input logic [11:0] ra,
                          output logic [31:0] rd, output logic rv);
        @(negedge clk);
        wr_en = we; wr_addr = wa[11:2]; wr_data = wd;
        rd_en = re; rd_addr = ra[11:2];
        @(negedge clk);
        rd = rdata; rv = rvalid;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    function automatic logic [11:0] qa(input int base, input int q);
        return 12'(base + 4 * q);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] x; logic v;
        access(1'b1, a, d, 1'b0, 12'h0, x, v);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        logic v;
        access(1'b0, 12'h0, 32'h0, 1'b1, a, d, v);
    endtask

    task automatic t_reset_state();
        logic [31:0] d; logic v;
        access(1'b0, 12'h0, 32'h0, 1'b1, qa(CB, 0), d, v);
        chk("R1 count q0 after reset", d, 32'h0);
        chk("R1 rvalid after read", 32'(v), 32'h1);
        @(negedge clk);
        chk("R1 rvalid idle", 32'(rvalid), 32'h0);
        rd(PB, d);         chk("R1 nonempty word0 after reset", d, 32'h0);
        rd(PB + 12'h4, d); chk("R1 nonempty word1 after reset", d, 32'h0);
        rd(qa(QB, 5), d);  chk("R3 pop empty q5", d, 32'hFFFF_FFFF);
        rd(qa(CB, 5), d);  chk("R3 count q5 unchanged", d, 32'h0);
    endtask

    task automatic t_fifo_order();
        logic [31:0] d; logic v;
        access(1'b1, qa(QB, 3), 32'hA000_0000, 1'b1, qa(CB, 3), d, v);
        chk("R4 count read sees pre-push value", d, 32'h0);
        for (int i = 1; i < 5; i++) wr(qa(QB, 3), 32'hA000_0000 + 32'(i));
        rd(qa(CB, 3), d); chk("R4 count q3 after pushes", d, 32'd5);
        rd(qa(CB, 3), d); chk("R4 count read again unchanged", d, 32'd5);
        for (int i = 0; i < 5; i++) begin
            rd(qa(QB, 3), d);
            chk("R2 fifo order q3", d, 32'hA000_0000 + 32'(i));
        end
        rd(qa(QB, 3), d); chk("R3 pop after drain q3", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_bitmap();
        logic [31:0] d;
        wr(qa(QB, 0), 32'h0000_0111);
        wr(qa(QB, 63), 32'h0000_0222);
        rd(PB, d);          chk("R5 nonempty word0 bit0", d, 32'h0000_0001);
        rd(PB + 12'h4, d);  chk("R5 nonempty word1 bit31", d, 32'h8000_0000);
        rd(PB + 12'h10, d); chk("R5 peek word4 zero", d, 32'h0);
        rd(qa(QB, 63), d);  chk("R2 pop q63", d, 32'h0000_0222);
        rd(qa(QB, 0), d);   chk("R2 pop q0", d, 32'h0000_0111);
        rd(PB, d);          chk("R5 nonempty word0 cleared", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < 17; i++) wr(qa(QB, 10), 32'hB000_0000 + 32'(i));
        rd(qa(CB, 10), d);  chk("R6 count q10 saturates at 16", d, 32'd16);
        rd(PB + 12'h8, d);  chk("R6 overflow word2 bit10", d, 32'h0000_0400);
        rd(PB + 12'hC, d);  chk("R6 overflow word3 clear", d, 32'h0);
        rd(qa(QB, 10), d);  chk("R6 head after overflow", d, 32'hB000_0000);
        rd(PB + 12'h8, d);  chk("R6 overflow sticky after pop", d, 32'h0000_0400);
        for (int i = 1; i < 16; i++) begin
            rd(qa(QB, 10), d);
            chk("R6 stored entries intact", d, 32'hB000_0000 + 32'(i));
        end
        rd(qa(QB, 10), d);  chk("R6 dropped push not stored", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_queue_reset();
        logic [31:0] d;
        for (int i = 0; i < 3; i++) wr(qa(QB, 20), 32'hC000_0000 + 32'(i));
        wr(qa(QB, 21), 32'hC100_0000);
        wr(RB, 32'hFFFF_FF14);
        rd(qa(CB, 20), d);  chk("R7 count q20 after reset", d, 32'h0);
        rd(qa(QB, 20), d);  chk("R7 pop q20 after reset", d, 32'hFFFF_FFFF);
        rd(qa(CB, 21), d);  chk("R7 neighbour q21 untouched", d, 32'd1);
        rd(qa(QB, 21), d);  chk("R7 neighbour q21 data", d, 32'hC100_0000);
        wr(RB, 32'd10);
        rd(PB + 12'h8, d);  chk("R7 overflow q10 cleared", d, 32'h0);
        rd(RB, d);          chk("R10 reset register reads zero", d, 32'h0);
    endtask

    task automatic t_collisions();
        logic [31:0] d; logic v;
        wr(qa(QB, 7), 32'hD000_0001);
        wr(qa(QB, 7), 32'hD000_0002);
        access(1'b1, RB, 32'd7, 1'b1, qa(QB, 7), d, v);
        chk("R8 pop loses to reset", d, 32'hFFFF_FFFF);
        rd(qa(CB, 7), d);   chk("R8 q7 empty after clash", d, 32'h0);
        for (int i = 0; i < 16; i++) wr(qa(QB, 12), 32'h1200 + 32'(i));
        access(1'b1, qa(QB, 12), 32'h0000_ABCD, 1'b1, qa(QB, 12), d, v);
        chk("R9 pop during full push", d, 32'h1200);
        rd(qa(CB, 12), d);  chk("R9 count stays 16", d, 32'd16);
        rd(PB + 12'h8, d);  chk("R9 no overflow flagged", d, 32'h0);
        for (int i = 1; i < 16; i++) begin
            rd(qa(QB, 12), d);
            chk("R9 drain order", d, 32'h1200 + 32'(i));
        end
        rd(qa(QB, 12), d);  chk("R9 pushed entry last", d, 32'h0000_ABCD);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(qa(CB, 30), 32'd5);
        wr(PB, 32'hFFFF_FFFF);
        wr(12'h000, 32'h1234_5678);
        rd(qa(CB, 30), d);  chk("R10 count write ignored", d, 32'h0);
        rd(PB, d);          chk("R10 peek write ignored", d, 32'h0);
        rd(12'h000, d);     chk("R10 unmapped read zero", d, 32'h0);
        rd(qa(QB, 30), d);  chk("R10 q30 still empty", d, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_fifo_order();
        t_bitmap();
        t_overflow();
        t_queue_reset();
        t_collisions();
        t_ignored();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule